// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a two-channel serial audio stream as a slave. A bit clock, a frame (channel-select) clock and a serial data line come in from off-block. They pass through a synchronizer into the system clock domain and are decoded there. A 3-bit format select picks one of six framing variants. The variants differ in three ways: which frame-clock level marks the left channel, where the most significant bit sits relative to the frame-clock edge, and how many bits form a word. Each stereo frame yields one pair of 24-bit two's-complement samples, presented together with a one-cycle strobe.

Data is taken on the rising edge of the bit clock and arrives most significant bit first. In the justified-to-start formats, the word is captured from the start of the half-frame. A word shorter than 24 bits is padded with zeros below its least significant bit. In the justified-to-end formats, the receiver keeps the final N bits before the next frame-clock edge and sign-extends them to 24 bits. Each justified-to-end width requires a minimum number of bit clocks per frame. A frame with fewer bit clocks than that is reported on an error pulse, and its samples are dropped.

Top module: `sar_rx`

## Requirements
- R1: `fmt_sel` encodes the framing: 3'b000 start-justified, 3'b001 one-bit-delayed (I2S), 3'b010 end-justified 16-bit, 3'b011 end-justified 24-bit, 3'b100 end-justified 20-bit, 3'b101 end-justified 18-bit; 3'b110 and 3'b111 are reserved.
- R2: Serial data is taken at the rising edge of the bit clock, most significant bit first. A change on the data line while the bit clock is high has no effect on the captured word.
- R3: In start-justified mode, a high frame clock marks the left channel. The MSB is on the first bit clock of the half-frame, at most 24 bits are kept, and a half-frame with fewer than 24 bits is zero-padded at the LSB end.
- R4: In I2S mode, a low frame clock marks the left channel. The first bit clock after the frame-clock edge is skipped and the MSB is on the second. Capture and padding are otherwise as in R3.
- R5: In end-justified modes, a high frame clock marks the left channel. The sample is the last N bits (N = 16, 24, 20 or 18) before the next frame-clock edge, sign-extended from bit N-1 to 24 bits.
- R6: A frame is a left half-frame followed by a right half-frame. Its samples appear together with a one-cycle `sample_stb`, which is raised 3 clock edges after the first bit-clock rise of the next half-frame reaches the inputs. It is never high on two consecutive cycles.
- R7: End-justified frames need at least 32 (16-bit), 48 (24-bit), 40 (20-bit) or 36 (18-bit) bit clocks over both halves. A shorter frame raises `frame_err` for one cycle instead of `sample_stb`. Start-justified and I2S frames have no minimum.
- R8: With a reserved format code, each completed frame strobes out zero on both channels.
- R9: After reset, the outputs are zero and both pulses are low. Bits before the first frame-clock edge are discarded, and a right half-frame without a complete left half-frame before it produces no strobe and no error.
- R10: `left_out` and `right_out` change only on a `sample_stb` cycle. An errored frame leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Frame / channel-select clock |
| sdata_in | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Framing select, encoded per R1 |
| left_out | output | 24 | Left sample, two's complement |
| right_out | output | 24 | Right sample, two's complement |
| sample_stb | output | 1 | One-cycle pulse, new frame on the outputs |
| frame_err | output | 1 | One-cycle pulse, frame too short and dropped |

## Verification
Both pulses and the sample update come 3 system-clock edges after the bench drives the bit-clock rise that closes a frame: two synchronizer stages, then one output register. The bench records the cycle count at each bit-clock rise it drives. It samples every output on the falling clock edge and checks that each strobe arrives exactly 3 cycles after the last recorded rise. Stimulus holds each bit-clock phase for several system cycles, so the strobe, error and sample values are always read inside the high phase of the closing bit clock, before the next bit begins.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int SAMPLE_W = 24;
  localparam int KCAP_W   = $clog2(SAMPLE_W + 1);

  localparam logic [2:0] FMT_LJ   = 3'd0;
  localparam logic [2:0] FMT_I2S  = 3'd1;
  localparam logic [2:0] FMT_RJ16 = 3'd2;
  localparam logic [2:0] FMT_RJ24 = 3'd3;
  localparam logic [2:0] FMT_RJ20 = 3'd4;
  localparam logic [2:0] FMT_RJ18 = 3'd5;

  function automatic logic fmt_reserved(input logic [2:0] f);
    return f[2] & f[1];
  endfunction

  function automatic logic fmt_is_rj(input logic [2:0] f);
    return (f == FMT_RJ16) || (f == FMT_RJ24) || (f == FMT_RJ20) || (f == FMT_RJ18);
  endfunction

  // word length of an end-justified format
  function automatic int rj_width(input logic [2:0] f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      default:  return SAMPLE_W;
    endcase
  endfunction

  // bit clocks a whole frame must carry
  function automatic int min_frame_bclk(input logic [2:0] f);
    case (f)
      FMT_RJ16: return 32;
      FMT_RJ24: return 48;
      FMT_RJ20: return 40;
      FMT_RJ18: return 36;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] raw,
                                                      input int n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++) r[i] = (i < n) ? raw[i] : raw[n-1];
    return r;
  endfunction

  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [KCAP_W-1:0] k);
    return raw << (SAMPLE_W - int'(k));
  endfunction

  function automatic logic [SAMPLE_W-1:0] finalize_half(input logic [SAMPLE_W-1:0] raw,
                                                        input logic [KCAP_W-1:0] k,
                                                        input logic [2:0] f);
    if (fmt_reserved(f))   return '0;
    else if (fmt_is_rj(f)) return sign_extend(raw, rj_width(f));
    else                   return msb_align(raw, k);
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_half_engine.sv
module sar_half_engine
  import sar_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  input  logic                bit_in,
  input  logic                lr_in,
  input  logic [2:0]          fmt,
  output logic                half_done,
  output logic [SAMPLE_W-1:0] half_word,
  output logic [CNT_W-1:0]    half_cnt,
  output logic                half_lr
);
  logic [SAMPLE_W-1:0] sr, sr_base, sr_nxt;
  logic [CNT_W-1:0]    cnt, idx, cnt_nxt;
  logic [KCAP_W-1:0]   kcap, k_base, k_nxt;
  logic                lr_prev, primed, in_half;
  logic                lr_edge, take, rj_mode;
  logic [CNT_W-1:0]    skip;

  assign lr_edge   = rise & primed & (lr_in != lr_prev);
  assign half_done = lr_edge & in_half;
  assign half_word = finalize_half(sr, kcap, fmt);
  assign half_cnt  = cnt;
  assign half_lr   = lr_prev;
  assign rj_mode   = fmt_is_rj(fmt);
  assign skip      = {{(CNT_W-1){1'b0}}, fmt == FMT_I2S};

  always_comb begin
    idx     = lr_edge ? '0 : cnt;
    sr_base = lr_edge ? '0 : sr;
    k_base  = lr_edge ? '0 : kcap;
    if (rj_mode) take = 1'b1;
    else         take = (idx >= skip) && (k_base < KCAP_W'(SAMPLE_W));
    sr_nxt  = take ? {sr_base[SAMPLE_W-2:0], bit_in} : sr_base;
    k_nxt   = (take && !rj_mode) ? k_base + 1'b1 : k_base;
    if (lr_edge)        cnt_nxt = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (&cnt)      cnt_nxt = cnt;
    else                cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      kcap    <= '0;
      lr_prev <= 1'b0;
      primed  <= 1'b0;
      in_half <= 1'b0;
    end else if (rise) begin
      primed  <= 1'b1;
      lr_prev <= lr_in;
      sr      <= sr_nxt;
      kcap    <= k_nxt;
      cnt     <= cnt_nxt;
      if (lr_edge) in_half <= 1'b1;
    end
  end

  // R3: never more than one sample width of bits kept from the start
  p_cap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kcap <= KCAP_W'(SAMPLE_W));

  // R9: no half-frame can complete before one has been opened by an edge
  p_no_early_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !half_done);
endmodule

// File: rtl/sar_frame_asm.sv
module sar_frame_asm
  import sar_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_done,
  input  logic [SAMPLE_W-1:0] half_word,
  input  logic [CNT_W-1:0]    half_cnt,
  input  logic                half_lr,
  input  logic [2:0]          fmt,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_stb,
  output logic                frame_err
);
  logic [SAMPLE_W-1:0] left_hold;
  logic [CNT_W-1:0]    left_cnt;
  logic                left_ok;
  logic                half_left;
  logic [CNT_W:0]      frame_bclk;
  logic                enough;

  assign half_left  = (fmt == FMT_I2S) ? ~half_lr : half_lr;
  assign frame_bclk = {1'b0, left_cnt} + {1'b0, half_cnt};
  assign enough     = int'(frame_bclk) >= min_frame_bclk(fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      left_cnt   <= '0;
      left_ok    <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      sample_stb <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      frame_err  <= 1'b0;
      if (half_done) begin
        if (half_left) begin
          left_hold <= half_word;
          left_cnt  <= half_cnt;
          left_ok   <= 1'b1;
        end else begin
          left_ok <= 1'b0;
          if (left_ok) begin
            if (enough) begin
              left_out   <= left_hold;
              right_out  <= half_word;
              sample_stb <= 1'b1;
            end else begin
              frame_err <= 1'b1;
            end
          end
        end
      end
    end
  end

  p_stb_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && frame_err));

  p_err_only_rj_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> fmt_is_rj($past(fmt)));

  p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> ($stable(left_out) && $stable(right_out)));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && fmt_reserved($past(fmt))) |-> (left_out == '0 && right_out == '0));

  p_rj16_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && $past(fmt) == FMT_RJ16) |->
      (($countones(left_out[SAMPLE_W-1:15]) == 0) ||
       ($countones(left_out[SAMPLE_W-1:15]) == SAMPLE_W - 15)));
endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sdata_in,
  input  logic [2:0]          fmt_sel,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_stb,
  output logic                frame_err
);
  localparam int LINES = 3;

  logic [LINES-1:0]    pins_q;
  logic                bclk_s, lr_s, data_s, bclk_d, bclk_rise;
  logic                half_done, half_lr;
  logic [SAMPLE_W-1:0] half_word;
  logic [CNT_W-1:0]    half_cnt;

  sar_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({bclk_in, lrclk_in, sdata_in}),
    .q (pins_q)
  );

  assign {bclk_s, lr_s, data_s} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s;
  end

  assign bclk_rise = bclk_s & ~bclk_d;

  sar_half_engine #(.CNT_W(CNT_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (bclk_rise),
    .bit_in    (data_s),
    .lr_in     (lr_s),
    .fmt       (fmt_sel),
    .half_done (half_done),
    .half_word (half_word),
    .half_cnt  (half_cnt),
    .half_lr   (half_lr)
  );

  sar_frame_asm #(.CNT_W(CNT_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_done  (half_done),
    .half_word  (half_word),
    .half_cnt   (half_cnt),
    .half_lr    (half_lr),
    .fmt        (fmt_sel),
    .left_out   (left_out),
    .right_out  (right_out),
    .sample_stb (sample_stb),
    .frame_err  (frame_err)
  );

  p_single_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_half_needs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |-> bclk_rise);
endmodule

// File: tb/tb_sar_rx.sv
module tb_sar_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [23:0] left_out, right_out;
  logic        sample_stb, frame_err;

  int checks = 0, errors = 0;
  int cyc = 0, rise_cyc = 0, stb_lat = 0;
  int stb_cnt = 0, err_cnt = 0;
  bit glitch = 1'b0;

  sar_rx dut (
    .clk (clk), .rst_n (rst_n), .bclk_in (bclk), .lrclk_in (lrclk),
    .sdata_in (sdata), .fmt_sel (fmt), .left_out (left_out),
    .right_out (right_out), .sample_stb (sample_stb), .frame_err (frame_err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && sample_stb) begin
      stb_cnt = stb_cnt + 1;
      stb_lat = cyc - rise_cyc;
    end
    if (rst_n && frame_err) err_cnt = err_cnt + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int min_bits(input logic [2:0] f);
    case (f)
      3'd2: return 32;
      3'd3: return 48;
      3'd4: return 40;
      3'd5: return 36;
      default: return 0;
    endcase
  endfunction

  function automatic int rj_n(input logic [2:0] f);
    case (f)
      3'd2: return 16;
      3'd3: return 24;
      3'd4: return 20;
      default: return 18;
    endcase
  endfunction

  function automatic bit left_level(input logic [2:0] f);
    return (f == 3'd1) ? 1'b0 : 1'b1;
  endfunction

  // serial bit i of a half-frame of n bits carrying word w
  function automatic bit bit_for(input logic [2:0] f, input logic [23:0] w,
                                 input int n, input int i);
    int pos;
    bit junk;
    junk = bit'($urandom_range(0, 1));
    if (f == 3'd0) return (i < 24) ? w[23-i] : 1'b0;
    if (f == 3'd1) begin
      if (i == 0) return junk;
      return (i <= 24) ? w[24-i] : 1'b0;
    end
    if (f >= 3'd6) return junk;
    pos = n - 1 - i;
    return (pos < rj_n(f)) ? w[pos] : junk;
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w,
                                              input int n);
    int avail;
    logic [31:0] u;
    logic signed [31:0] t;
    if (f == 3'd0 || f == 3'd1) begin
      avail = (f == 3'd1) ? n - 1 : n;
      if (avail > 24) avail = 24;
      if (avail < 0) avail = 0;
      return w & (24'hFFFFFF << (24 - avail));
    end
    if (f >= 3'd6) return 24'h0;
    u = {8'h00, w} << (32 - rj_n(f));
    t = $signed(u) >>> (32 - rj_n(f));
    return t[23:0];
  endfunction

  task automatic send_bit(input bit lr, input bit d);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    rise_cyc = cyc;
    if (glitch) begin
      repeat (2) @(negedge clk);
      sdata = ~d;
      @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send_half(input logic [2:0] f, input bit lr, input logic [23:0] w,
                           input int n);
    for (int i = 0; i < n; i++) send_bit(lr, bit_for(f, w, n, i));
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0; glitch = 1'b0;
    repeat (3) @(negedge clk);
    stb_cnt = 0; err_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame_test(input string req, input logic [2:0] f,
                            input logic [23:0] l, input logic [23:0] r,
                            input int nl, input int nr, input bit use_glitch);
    bit ll, ok;
    logic [23:0] el, er;
    reset_dut();
    fmt = f;
    ll = left_level(f);
    send_half(f, ~ll, 24'($urandom), 6);
    glitch = use_glitch;
    send_half(f, ll, l, nl);
    send_half(f, ~ll, r, nr);
    glitch = 1'b0;
    send_bit(ll, 1'b0);
    repeat (6) @(negedge clk);
    ok = (nl + nr) >= min_bits(f);
    el = expect_word(f, l, nl);
    er = expect_word(f, r, nr);
    chk(stb_cnt == (ok ? 1 : 0), req, "strobe count", stb_cnt, ok ? 1 : 0);
    if (ok) begin
      chk(left_out == el, req, "left sample", left_out, el);
      chk(right_out == er, req, "right sample", right_out, er);
      chk(stb_lat == 3, "R6", "strobe latency", stb_lat, 3);
      chk(err_cnt == 0, "R7", "no error pulse", err_cnt, 0);
    end else begin
      chk(err_cnt == 1, "R7", "error pulse count", err_cnt, 1);
      chk(left_out == 24'h0 && right_out == 24'h0, "R10", "outputs held",
          {left_out, right_out}, 0);
    end
  endtask

  initial begin
    logic [23:0] a, b, c;
    logic [2:0]  f;
    int          n;
    void'($urandom(32'd4242));

    // R9: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_out == 0 && right_out == 0, "R9", "reset samples", {left_out, right_out}, 0);
    chk(!sample_stb && !frame_err, "R9", "reset pulses", {sample_stb, frame_err}, 0);

    // start-justified
    frame_test("R1/R3", 3'd0, 24'hA5C3E1, 24'h13579B, 32, 32, 1'b0);
    frame_test("R3", 3'd0, 24'hFEDCBA, 24'h7FFFFF, 16, 20, 1'b0);
    frame_test("R7", 3'd0, 24'hF00000, 24'hC00000, 3, 3, 1'b0);
    // R2: data flips while bit clock is high
    frame_test("R2", 3'd0, 24'h5A5A5A, 24'hC3C3C3, 32, 32, 1'b1);
    // I2S
    frame_test("R1/R4", 3'd1, 24'h800001, 24'h0FF0F0, 32, 32, 1'b0);
    frame_test("R4", 3'd1, 24'h9ABCDE, 24'h123456, 20, 21, 1'b0);
    // end-justified, at and below the minimum
    frame_test("R5", 3'd2, 24'h008123, 24'h007FFF, 16, 16, 1'b0);
    frame_test("R7", 3'd2, 24'h001234, 24'h004321, 16, 15, 1'b0);
    frame_test("R5", 3'd3, 24'h800000, 24'h7FFFFF, 24, 24, 1'b0);
    frame_test("R7", 3'd3, 24'h111111, 24'h222222, 24, 23, 1'b0);
    frame_test("R5", 3'd4, 24'h0F8001, 24'h07FFFE, 32, 32, 1'b0);
    frame_test("R7", 3'd4, 24'h0ABCDE, 24'h012345, 20, 19, 1'b0);
    frame_test("R5", 3'd5, 24'h020000, 24'h01FFFF, 18, 18, 1'b0);
    frame_test("R7", 3'd5, 24'h02AAAA, 24'h015555, 17, 18, 1'b0);
    // reserved codes
    frame_test("R8", 3'd6, 24'hFFFFFF, 24'hABCDEF, 32, 32, 1'b0);
    frame_test("R8", 3'd7, 24'h123456, 24'h654321, 24, 24, 1'b0);

    // R9: no edge before the first left half, so nothing completes
    reset_dut();
    fmt = 3'd0;
    send_half(3'd0, 1'b1, 24'hABCDEF, 32);
    send_half(3'd0, 1'b0, 24'h123456, 32);
    send_bit(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk(stb_cnt == 0 && err_cnt == 0, "R9", "unprimed frame ignored", stb_cnt + err_cnt, 0);

    // R10: good frame then short frame, outputs keep the good one
    reset_dut();
    fmt = 3'd2;
    a = 24'h00BEEF; b = 24'h001234; c = 24'h00AAAA;
    send_half(3'd2, 1'b0, 24'h0, 6);
    send_half(3'd2, 1'b1, a, 16);
    send_half(3'd2, 1'b0, b, 16);
    send_half(3'd2, 1'b1, c, 16);
    send_half(3'd2, 1'b0, c, 15);
    send_bit(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk(stb_cnt == 1, "R10", "one good frame", stb_cnt, 1);
    chk(err_cnt == 1, "R10", "one short frame", err_cnt, 1);
    chk(left_out == expect_word(3'd2, a, 16), "R10", "left kept", left_out,
        expect_word(3'd2, a, 16));
    chk(right_out == expect_word(3'd2, b, 16), "R10", "right kept", right_out,
        expect_word(3'd2, b, 16));

    // constrained random frames over the six defined formats
    for (int k = 0; k < 16; k++) begin
      f = 3'($urandom_range(0, 5));
      a = 24'($urandom);
      b = 24'($urandom);
      if (f >= 3'd2) n = $urandom_range(rj_n(f), 32);
      else           n = $urandom_range(8, 32);
      frame_test("R6", f, a, b, n, n, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule